// File: doc/BRIEF.md
# Addressed Three-Wire Display Serial Port

This block is the host-facing serial slave of a segment display controller. A host drives three lines into it (a chip-enable, a bit clock and a data line) and watches one open-drain return line. With chip-enable low the host clocks in a one-byte address. The address selects one of three things: a write of display and control data, a read of the key matrix result, or nothing at all. The payload then follows with chip-enable high. The display image is split into two halves of 48 bits. Each write frame carries one half. A trailing direction bit names the half, and the frame that fills the low half also carries the nine control bits.

All three serial inputs are oversampled by the system clock through synchronizers. Data is taken on rising bit-clock edges. Read data moves on falling bit-clock edges. The return line has two jobs. Between transfers it is pulled low to ask the host for a key read. During a write frame it is released. During a read frame it carries the key bits and then the sleep flag. The key scanner on the inside offers its result as a valid/ready pair. `key_valid` is the request and must stay high, with `key_data` stable, until `key_ready` accepts it. There is no back-pressure toward the host, because the serial side cannot be stalled.

After power-on the display stays blanked until both halves have been written by well-formed frames. The latches and the control register carry no reset. A later reset blanks the display again but keeps their contents.

Top module: `lcdp_serial_port`

## Requirements
- R1: The address byte is shifted in least-significant bit first on rising `ser_clk` edges while `ser_ce` is low, and it is decoded when `ser_ce` rises. 0x42 opens a write frame and 0x43 opens a read frame. Any other address makes the following payload change no latch and keeps the return line released while `ser_ce` is high.
- R2: A write frame whose 64th bit (direction) is 0 loads payload bits 1..48 into `disp_data[47:0]`, with payload bit k going to index k-1. Bits 55..63 load the control fields in this order: sleep_ctrl[0], sleep_ctrl[1], keyline_sel[0], keyline_sel[1], port_sel[0], port_sel[1], port_sel[2], seg_off, bias_half.
- R3: A write frame whose direction bit is 1 loads payload bits 1..48 into `disp_data[95:48]`, with payload bit k going to index 47+k, and leaves the control fields unchanged.
- R4: Latches change only when `ser_ce` falls. A frame is discarded if it does not hold exactly 64 payload bits, or if its filler bits are not all zero (bits 49..54 for direction 0, bits 49..63 for direction 1).
- R5: In a read frame the return line carries key bit 1 (`key_data[0]`) from the rise of `ser_ce` onward. It moves on to the next bit on each falling `ser_clk` edge, through `key_data[29]`. Bit 31 is the sleep acknowledge, which is 1 when either sleep_ctrl bit is set. After that the line is released. `ser_dout_low`=1 means the line is pulled to logic 0.
- R6: While `ser_ce` is low and the display is not blanked, `ser_dout_low` follows `key_valid`. While `ser_ce` is high outside a read frame, the line is released.
- R7: `key_ready` is a single-cycle pulse, raised when `ser_ce` falls at the end of a read frame that started with `key_valid` high. `key_valid` must be held until that pulse.
- R8: A read frame that starts with `key_valid` low gives a single-cycle `rd_stale` pulse and no `key_ready`. The frame still shifts out the current `key_data`.
- R9: `blank` is 1 from reset until the `ser_ce` fall at which both halves have been loaded since that reset. While `blank` is 1 the return line stays released, including during read frames, and neither `key_ready` nor `rd_stale` pulses.
- R10: `rst_n` does not clear `disp_data` or the control fields. Their values survive a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Active-low power-on reset |
| ser_ce | input | 1 | Chip-enable: low for the address, high for the payload |
| ser_clk | input | 1 | Serial bit clock from the host |
| ser_din | input | 1 | Serial data from the host |
| ser_dout_low | output | 1 | 1 pulls the open-drain return line low |
| key_valid | input | 1 | Key result offered by the scanner (read request) |
| key_data | input | 30 | Key bits; bit 0 is sent first |
| key_ready | output | 1 | Key result taken by a completed read |
| rd_stale | output | 1 | Pulse: read started with no pending request |
| disp_data | output | 96 | Display image, both halves |
| sleep_ctrl | output | 2 | Sleep control field |
| keyline_sel | output | 2 | Key-line/segment selection field |
| port_sel | output | 3 | Segment/general-output selection field |
| seg_off | output | 1 | Segments-off control bit |
| bias_half | output | 1 | Half-bias drive select |
| blank | output | 1 | Display held off until both halves are loaded |

## Verification
A wrong bit count or a misplaced payload index shows up on `disp_data` or on the control fields a few clocks after `ser_ce` falls. The bench compares those outputs against its model on every clock between frames. If the framing mode is corrupted, the return line behaves wrongly within a single bit period: it is pulled low during a write, or the read bits come out shifted by one. The capture of every read and write frame catches this. A faulty blank or load-tracking state shows on `blank` and on the return line's masking right after the frame that should have changed it.

// File: rtl/lcdp_pkg.sv
package lcdp_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_WR   = 2'd1,
    MODE_RD   = 2'd2,
    MODE_SKIP = 2'd3
  } mode_t;

  // Packed so that bit 0 is the first control bit received.
  typedef struct packed {
    logic       bias_half;
    logic       seg_off;
    logic [2:0] port_sel;
    logic [1:0] keyline_sel;
    logic [1:0] sleep_ctrl;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/lcdp_sync.sv
module lcdp_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  // Serial side carries no reset.
  always_ff @(posedge clk) begin
    chain[0] <= d;
    for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/lcdp_rx.sv
module lcdp_rx
  import lcdp_pkg::*;
#(
  parameter int                ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] WR_ADDR = 8'h42,
  parameter logic [ADDR_W-1:0] RD_ADDR = 8'h43,
  parameter int                FRAME_W = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ce,
  input  logic               din,
  input  logic               sclk_rise,
  input  logic               ce_rise,
  input  logic               ce_fall,
  output mode_t              mode,
  output logic [FRAME_W-1:0] payload,
  output logic               frame_ok,
  output logic               rd_start,
  output logic               rd_end
);
  localparam int CNT_W = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);

  logic [ADDR_W-1:0] addr_sr;
  logic [CNT_W-1:0]  cnt;

  // Address shifter: first bit received ends up in bit 0.
  always_ff @(posedge clk) begin
    if (!ce && sclk_rise) addr_sr <= {din, addr_sr[ADDR_W-1:1]};
  end

  // Payload shifter, no reset: the first payload bit ends up in bit 0.
  always_ff @(posedge clk) begin
    if (ce && sclk_rise && mode == MODE_WR) payload <= {din, payload[FRAME_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= MODE_IDLE;
      cnt  <= '0;
    end else begin
      if (ce_rise) begin
        cnt <= '0;
        if (addr_sr == WR_ADDR)      mode <= MODE_WR;
        else if (addr_sr == RD_ADDR) mode <= MODE_RD;
        else                         mode <= MODE_SKIP;
      end else if (ce_fall) begin
        mode <= MODE_IDLE;
      end else if (ce && sclk_rise && mode == MODE_WR && cnt != CNT_SAT) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign frame_ok = ce_fall && (mode == MODE_WR) && (cnt == CNT_FULL);
  assign rd_start = ce_rise && (addr_sr == RD_ADDR);
  assign rd_end   = ce_fall && (mode == MODE_RD);
endmodule

// File: rtl/lcdp_tx.sv
module lcdp_tx #(
  parameter int KEY_W = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             active,
  input  logic             sclk_fall,
  input  logic [KEY_W-1:0] key_data,
  input  logic             sleep_ack,
  output logic             bit_out
);
  localparam int OUT_W = KEY_W + 1;

  logic [OUT_W-1:0] out_sr;

  // Ones fill behind the data, so the line is released once the frame is used up.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      out_sr <= '1;
    else if (load)                   out_sr <= {sleep_ack, key_data};
    else if (active && sclk_fall)    out_sr <= {1'b1, out_sr[OUT_W-1:1]};
  end

  assign bit_out = out_sr[0];
endmodule

// File: rtl/lcdp_serial_port.sv
module lcdp_serial_port
  import lcdp_pkg::*;
#(
  parameter int                HALF_W      = 48,
  parameter int                FRAME_W     = 64,
  parameter int                KEY_W       = 30,
  parameter int                ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] WR_ADDR     = 8'h42,
  parameter logic [ADDR_W-1:0] RD_ADDR     = 8'h43,
  parameter int                SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ser_ce,
  input  logic                ser_clk,
  input  logic                ser_din,
  output logic                ser_dout_low,
  input  logic                key_valid,
  input  logic [KEY_W-1:0]    key_data,
  output logic                key_ready,
  output logic                rd_stale,
  output logic [2*HALF_W-1:0] disp_data,
  output logic [1:0]          sleep_ctrl,
  output logic [1:0]          keyline_sel,
  output logic [2:0]          port_sel,
  output logic                seg_off,
  output logic                bias_half,
  output logic                blank
);
  localparam int DIR_BIT  = FRAME_W - 1;
  localparam int CTRL_LSB = DIR_BIT - CTRL_W;
  localparam int FILL_LO  = CTRL_LSB - HALF_W;
  localparam int FILL_HI  = DIR_BIT - HALF_W;

  // Synchronize and find the edges.
  logic [2:0] s_vec;
  logic       ce_s, sclk_s, din_s, ce_d, sclk_d;
  logic       ce_rise, ce_fall, sclk_rise, sclk_fall;

  lcdp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d   ({ser_ce, ser_clk, ser_din}),
    .q   (s_vec)
  );

  assign {ce_s, sclk_s, din_s} = s_vec;

  always_ff @(posedge clk) begin
    ce_d   <= ce_s;
    sclk_d <= sclk_s;
  end

  assign ce_rise   =  ce_s   & ~ce_d;
  assign ce_fall   = ~ce_s   &  ce_d;
  assign sclk_rise =  sclk_s & ~sclk_d;
  assign sclk_fall = ~sclk_s &  sclk_d;

  // Receive path.
  mode_t              mode;
  logic [FRAME_W-1:0] payload;
  logic               frame_ok, rd_start, rd_end;

  lcdp_rx #(
    .ADDR_W (ADDR_W), .WR_ADDR (WR_ADDR), .RD_ADDR (RD_ADDR), .FRAME_W (FRAME_W)
  ) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce        (ce_s),
    .din       (din_s),
    .sclk_rise (sclk_rise),
    .ce_rise   (ce_rise),
    .ce_fall   (ce_fall),
    .mode      (mode),
    .payload   (payload),
    .frame_ok  (frame_ok),
    .rd_start  (rd_start),
    .rd_end    (rd_end)
  );

  // Frame decode and latches (no reset on data).
  logic  fill_lo_zero, fill_hi_zero, commit_lo, commit_hi;
  logic [HALF_W-1:0] disp_lo, disp_hi;
  ctrl_t ctrl_q;

  assign fill_lo_zero = (payload[CTRL_LSB-1:HALF_W] == {FILL_LO{1'b0}});
  assign fill_hi_zero = (payload[DIR_BIT-1:HALF_W]  == {FILL_HI{1'b0}});
  assign commit_lo    = frame_ok & ~payload[DIR_BIT] & fill_lo_zero;
  assign commit_hi    = frame_ok &  payload[DIR_BIT] & fill_hi_zero;

  always_ff @(posedge clk) begin
    if (commit_lo) begin
      disp_lo <= payload[HALF_W-1:0];
      ctrl_q  <= ctrl_t'(payload[DIR_BIT-1:CTRL_LSB]);
    end
    if (commit_hi) disp_hi <= payload[HALF_W-1:0];
  end

  assign disp_data   = {disp_hi, disp_lo};
  assign sleep_ctrl  = ctrl_q.sleep_ctrl;
  assign keyline_sel = ctrl_q.keyline_sel;
  assign port_sel    = ctrl_q.port_sel;
  assign seg_off     = ctrl_q.seg_off;
  assign bias_half   = ctrl_q.bias_half;

  // Blank until both halves have been loaded since reset.
  logic lo_seen, hi_seen, blank_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_seen <= 1'b0;
      hi_seen <= 1'b0;
      blank_q <= 1'b1;
    end else begin
      if (commit_lo) lo_seen <= 1'b1;
      if (commit_hi) hi_seen <= 1'b1;
      if ((commit_lo | lo_seen) & (commit_hi | hi_seen)) blank_q <= 1'b0;
    end
  end

  assign blank = blank_q;

  // Transmit path.
  logic tx_bit;

  lcdp_tx #(.KEY_W(KEY_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (rd_start),
    .active    (mode == MODE_RD),
    .sclk_fall (sclk_fall),
    .key_data  (key_data),
    .sleep_ack (|ctrl_q.sleep_ctrl),
    .bit_out   (tx_bit)
  );

  // Key handshake.
  logic req_at_start, key_ready_q, rd_stale_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_at_start <= 1'b0;
      key_ready_q  <= 1'b0;
      rd_stale_q   <= 1'b0;
    end else begin
      if (rd_start) req_at_start <= key_valid;
      key_ready_q <= rd_end   &  req_at_start & ~blank_q;
      rd_stale_q  <= rd_start & ~key_valid    & ~blank_q;
    end
  end

  assign key_ready = key_ready_q;
  assign rd_stale  = rd_stale_q;

  // Open-drain return line.
  always_comb begin
    if (blank_q)              ser_dout_low = 1'b0;
    else if (mode == MODE_RD) ser_dout_low = ~tx_bit;
    else if (ce_s)            ser_dout_low = 1'b0;
    else                      ser_dout_low = key_valid;
  end
endmodule

// File: rtl/lcdp_port_chk.sv
module lcdp_port_chk
  import lcdp_pkg::*;
#(
  parameter int DISP_W = 96
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_s,
  input logic              ce_fall,
  input mode_t             mode,
  input logic              blank,
  input logic              ser_dout_low,
  input logic              key_valid,
  input logic              key_ready,
  input logic              rd_stale,
  input logic [DISP_W-1:0] disp_data
);
  p_blank_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> !ser_dout_low);

  p_unblank_on_cefall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(blank) |-> $past(ce_fall));

  p_ce_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_s && mode != MODE_RD) |-> !ser_dout_low);

  p_latch_on_cefall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(disp_data) |-> $past(ce_fall));

  p_ready_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    key_ready |=> !key_ready);

  p_ready_with_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    key_ready |-> key_valid);

  p_stale_no_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stale |-> $past(!key_valid));
endmodule

bind lcdp_serial_port lcdp_port_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ce_s         (ce_s),
  .ce_fall      (ce_fall),
  .mode         (mode),
  .blank        (blank),
  .ser_dout_low (ser_dout_low),
  .key_valid    (key_valid),
  .key_ready    (key_ready),
  .rd_stale     (rd_stale),
  .disp_data    (disp_data)
);

// File: tb/lcdp_serial_port_tb.sv
module lcdp_serial_port_tb;
  localparam int HP = 8;

  logic        clk = 1'b0;
  logic        rst_n, ser_ce, ser_clk, ser_din, key_valid;
  logic [29:0] key_data;
  logic        ser_dout_low, key_ready, rd_stale, blank, seg_off, bias_half;
  logic [95:0] disp_data;
  logic [1:0]  sleep_ctrl, keyline_sel;
  logic [2:0]  port_sel;

  always #2 clk = ~clk;

  lcdp_serial_port u_dut (
    .clk (clk), .rst_n (rst_n), .ser_ce (ser_ce), .ser_clk (ser_clk), .ser_din (ser_din),
    .ser_dout_low (ser_dout_low), .key_valid (key_valid), .key_data (key_data),
    .key_ready (key_ready), .rd_stale (rd_stale), .disp_data (disp_data),
    .sleep_ctrl (sleep_ctrl), .keyline_sel (keyline_sel), .port_sel (port_sel),
    .seg_off (seg_off), .bias_half (bias_half), .blank (blank)
  );

  int checks = 0, failures = 0, rdy_cnt = 0, stale_cnt = 0;
  bit finished = 0;

  // Behavioural model state.
  bit          chk_on = 0, has_lo = 0, has_hi = 0, seen_lo = 0, seen_hi = 0;
  logic        exp_blank = 1'b1;
  logic [47:0] exp_lo, exp_hi;
  logic [8:0]  exp_ctrl;

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) begin
    if (key_ready) rdy_cnt++;
    if (rd_stale)  stale_cnt++;
  end

  // Per-clock comparison between frames.
  always @(negedge clk) begin
    if (chk_on && rst_n) begin
      check("R9 blank", 128'(blank), 128'(exp_blank));
      check("R6 dout", 128'(ser_dout_low), 128'(!exp_blank && key_valid && !ser_ce));
      if (has_lo) begin
        check("R2 lo", 128'(disp_data[47:0]), 128'(exp_lo));
        check("R2 ctrl", 128'({bias_half, seg_off, port_sel, keyline_sel, sleep_ctrl}), 128'(exp_ctrl));
      end
      if (has_hi) check("R3 hi", 128'(disp_data[95:48]), 128'(exp_hi));
    end
  end

  function automatic logic [127:0] mk_wr(input logic [47:0] half, input logic [8:0] c, input logic dir);
    logic [127:0] v = '0;
    v[47:0] = half;
    if (!dir) v[62:54] = c;
    v[63] = dir;
    return v;
  endfunction

  task automatic set_kv(input logic v);
    chk_on = 0;
    key_valid = v;
    tick(6);
    chk_on = 1;
  endtask

  // One whole frame; cap[i] is the return-line level seen before rising edge i.
  task automatic send_frame(input logic [7:0] addr, input logic [127:0] v, input int n,
                            output logic [127:0] cap);
    cap = '1;
    chk_on = 0;
    ser_ce = 0;
    for (int i = 0; i < 8; i++) begin
      ser_din = addr[i]; tick(HP); ser_clk = 1; tick(HP); ser_clk = 0;
    end
    tick(HP); ser_ce = 1; tick(HP);
    for (int i = 0; i < n; i++) begin
      ser_din = v[i]; tick(HP);
      cap[i] = !ser_dout_low;
      ser_clk = 1; tick(HP); ser_clk = 0;
    end
    tick(HP); ser_ce = 0; tick(HP);
    if (addr == 8'h42 && n == 64) begin
      if (!v[63] && v[53:48] == 0) begin
        exp_lo = v[47:0]; exp_ctrl = v[62:54]; has_lo = 1; seen_lo = 1;
      end else if (v[63] && v[62:48] == 0) begin
        exp_hi = v[47:0]; has_hi = 1; seen_hi = 1;
      end
      if (seen_lo && seen_hi) exp_blank = 0;
    end
    chk_on = 1;
  endtask

  logic [127:0] cap;
  int r0, s0;

  initial begin
    rst_n = 0; ser_ce = 0; ser_clk = 0; ser_din = 0; key_valid = 0;
    key_data = 30'h2A5C_3E19;
    tick(5);
    check("R9 reset blank", 128'(blank), 128'(1));
    check("R9 reset dout", 128'(ser_dout_low), 128'(0));
    check("R7 reset ready", 128'(key_ready), 128'(0));
    rst_n = 1; tick(3); chk_on = 1;

    // Read while blanked: line stays released, no pulses.
    set_kv(1);
    s0 = stale_cnt; r0 = rdy_cnt;
    send_frame(8'h43, '0, 31, cap);
    check("R9 blank read", cap[30:0], {31{1'b1}});
    check("R9 no pulses", 128'(rdy_cnt - r0 + stale_cnt - s0), 128'(0));
    set_kv(0);

    // Low half plus control.
    send_frame(8'h42, mk_wr(48'hC3A5_0F1E_7D96, 9'b1_0_101_10_00, 0), 64, cap);
    check("R2 lo loaded", 128'(disp_data[47:0]), 128'(48'hC3A5_0F1E_7D96));
    check("R2 bias", 128'({bias_half, port_sel, keyline_sel}), 128'({1'b1, 3'b101, 2'b10}));
    check("R9 still blank", 128'(blank), 128'(1));

    // Discarded frames for the high half.
    send_frame(8'h42, mk_wr(48'h1111_2222_3333, 9'h0, 1), 63, cap);
    check("R4 short frame", 128'(blank), 128'(1));
    send_frame(8'h42, mk_wr(48'h1111_2222_3333, 9'h0, 1), 65, cap);
    check("R4 long frame", 128'(blank), 128'(1));
    send_frame(8'h42, mk_wr(48'h1111_2222_3333, 9'h0, 1) | (128'd1 << 50), 64, cap);
    check("R4 filler", 128'(blank), 128'(1));
    send_frame(8'h44, mk_wr(48'h1111_2222_3333, 9'h0, 1), 64, cap);
    check("R1 foreign addr", 128'(blank), 128'(1));

    // Valid high half releases blank.
    send_frame(8'h42, mk_wr(48'h8E71_4B2D_96F0, 9'h0, 1), 64, cap);
    check("R3 hi loaded", 128'(disp_data[95:48]), 128'(48'h8E71_4B2D_96F0));
    check("R9 unblank", 128'(blank), 128'(0));

    // Request shown idle, masked during a write and a foreign frame.
    set_kv(1);
    check("R6 request", 128'(ser_dout_low), 128'(1));
    send_frame(8'h42, mk_wr(48'h0123_4567_89AB, 9'b0_1_010_01_00, 0), 64, cap);
    check("R6 masked write", cap[63:0], {64{1'b1}});
    send_frame(8'h51, '0, 20, cap);
    check("R1 foreign released", cap[19:0], {20{1'b1}});

    // Read with a pending request.
    r0 = rdy_cnt; s0 = stale_cnt;
    send_frame(8'h43, '0, 31, cap);
    check("R5 key bits", cap[30:0], {1'b0, key_data});
    check("R7 ready pulse", 128'(rdy_cnt - r0), 128'(1));
    check("R8 no stale", 128'(stale_cnt - s0), 128'(0));
    set_kv(0);

    // Read with no request pending.
    key_data = 30'h1F0F_00F3;
    r0 = rdy_cnt; s0 = stale_cnt;
    send_frame(8'h43, '0, 33, cap);
    check("R8 stale pulse", 128'(stale_cnt - s0), 128'(1));
    check("R8 no ready", 128'(rdy_cnt - r0), 128'(0));
    check("R8 data out", cap[32:0], {2'b11, 1'b0, key_data});

    // Sleep flag appears after the key bits.
    send_frame(8'h42, mk_wr(48'hFFFF_0000_A5A5, 9'b0_0_000_00_10, 0), 64, cap);
    set_kv(1);
    key_data = 30'h0000_0001;
    send_frame(8'h43, '0, 31, cap);
    check("R5 sleep ack", cap[30:0], {1'b1, key_data});
    set_kv(0);

    // Reset keeps the latches.
    chk_on = 0;
    rst_n = 0; tick(3);
    check("R9 blank again", 128'(blank), 128'(1));
    check("R10 disp kept", 128'(disp_data), 128'({48'h8E71_4B2D_96F0, 48'hFFFF_0000_A5A5}));
    check("R10 ctrl kept", 128'(sleep_ctrl), 128'(2'b10));
    rst_n = 1; tick(3);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule